// File: doc/BRIEF.md
# Vector Length Control Register Unit

This block holds the user-mode vector length control state: the maximum vector length, the current vector length, and the source and destination element offsets. Software reaches it through a single-cycle control-register access port. Three addresses are mapped. One holds the maximum length, one holds the current length, and one holds a packed snapshot of all four values. The snapshot lets a context switch save and restore everything with one read and one write.

The current-length register does not behave like a plain swap register. A write limits the value to the maximum length and answers with the value that was actually set, not the previous one. Lengths are stored from 1 to 64, so the packed word holds each length minus one. A register-form write that would set a length to zero cannot be represented there, so it is refused with a one-cycle exception and nothing changes. Writes to the packed word keep the offsets below the new current length. The response (read data and exception) is given in the same cycle as the access. State updates on the following clock edge.

Top module: `vl_csr_unit`

## Requirements
- R1: After synchronous reset the maximum length and the current length are both 1 and both offsets are 0, so a read of the packed word returns 0.
- R2: A write to the maximum-length address (default 0xC21) sets it to the smaller of the value and 64 and returns the previous maximum. The register form uses the whole write word. The immediate form (write word bits 4:0) uses the immediate plus one.
- R3: A write to the current-length address (default 0xC20) sets the current length to the smaller of the value and the maximum length.
- R4: A current-length write returns the newly set current length as its read data, not the previous value.
- R5: An immediate-form current-length write uses the immediate plus one as the value, so an immediate of 0 sets a length of 1 and raises no exception.
- R6: A register-form write of zero to the current-length or maximum-length address raises the exception in the same cycle, for that cycle only, returns read data 0 and changes no register.
- R7: When a maximum-length write lowers the maximum below the current length, the current length drops to the new maximum.
- R8: The packed word at address 0xC22 holds the maximum length minus one in bits 5:0, the current length minus one in bits 11:6, the source offset in bits 17:12 and the destination offset in bits 23:18. All higher bits read as zero.
- R9: A packed-word write sets the maximum length from bits 5:0 plus one. It then sets the current length from bits 11:6 plus one, limited to the new maximum. It returns the previous packed word, and bits above 23 are ignored.
- R10: A packed-word write sets each offset to the smaller of its field and the new current length minus one.
- R11: When the destination-is-zero flag is set, the read data is 0, but any write still takes effect.
- R12: A read-only access, or any access to an unmapped address, changes no register and raises no exception. An unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access strobe, one cycle per access |
| acc_wr | input | 1 | Access writes (0 = read only) |
| acc_imm | input | 1 | Immediate form (value taken from acc_wdata[4:0]) |
| acc_rd_zero | input | 1 | Destination register is the zero register |
| acc_addr | input | 12 | Control register address |
| acc_wdata | input | 32 | Write value or immediate |
| rsp_rdata | output | 32 | Read data for the access, same cycle |
| rsp_exc | output | 1 | Illegal-value exception, same cycle |

## Verification
The assertions assume that an access strobe lasts one cycle per access and that the access controls are steady while the strobe is high. They also assume that no access arrives in the cycle reset is released. The bench drives every access from the falling edge for exactly one cycle and leaves an idle cycle after reset. It samples the same-cycle response before the next rising edge, and then reads the registers back through the port to see the effect of each write. The scenarios cover both write forms and zero values. They also cover a length above the limit, a maximum that falls below the current length, offsets above the new length, and reserved bits set in the packed word.

// File: rtl/vlcsr_pkg.sv
package vlcsr_pkg;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_MAX   = 2'd1,
    SEL_CUR   = 2'd2,
    SEL_PACK  = 2'd3
  } csr_sel_e;

endpackage

// File: rtl/vl_csr_decode.sv
module vl_csr_decode
  import vlcsr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] ADDR_CUR  = 12'hC20,
  parameter logic [ADDR_W-1:0] ADDR_MAX  = 12'hC21,
  parameter logic [ADDR_W-1:0] ADDR_PACK = 12'hC22
) (
  input  logic [ADDR_W-1:0] addr,
  output csr_sel_e          sel
);

  always_comb begin
    if (addr == ADDR_CUR)       sel = SEL_CUR;
    else if (addr == ADDR_MAX)  sel = SEL_MAX;
    else if (addr == ADDR_PACK) sel = SEL_PACK;
    else                        sel = SEL_NONE;
  end

endmodule

// File: rtl/vl_len_limit.sv
module vl_len_limit #(
  parameter int VW = 32,
  parameter int LW = 7
) (
  input  logic [VW-1:0] value,
  input  logic [LW-1:0] limit,
  output logic [LW-1:0] result
);

  logic [VW-1:0] limit_ext;

  assign limit_ext = VW'(limit);

  always_comb begin
    if (value > limit_ext) result = limit;
    else                   result = value[LW-1:0];
  end

endmodule

// File: rtl/vl_state_codec.sv
module vl_state_codec #(
  parameter int XLEN  = 32,
  parameter int LEN_W = 6
) (
  input  logic [LEN_W:0]   max_len,
  input  logic [LEN_W:0]   cur_len,
  input  logic [LEN_W-1:0] src_off,
  input  logic [LEN_W-1:0] dst_off,
  output logic [XLEN-1:0]  packed_word,
  input  logic [XLEN-1:0]  in_word,
  output logic [LEN_W-1:0] f_max_m1,
  output logic [LEN_W-1:0] f_cur_m1,
  output logic [LEN_W-1:0] f_src,
  output logic [LEN_W-1:0] f_dst
);

  localparam int FIELDS = 4;
  localparam int USED_W = FIELDS * LEN_W;

  logic [LEN_W:0] max_m1;
  logic [LEN_W:0] cur_m1;

  assign max_m1 = max_len - 1'b1;
  assign cur_m1 = cur_len - 1'b1;

  assign packed_word = XLEN'({dst_off, src_off, cur_m1[LEN_W-1:0], max_m1[LEN_W-1:0]});

  assign f_max_m1 = in_word[LEN_W-1:0];
  assign f_cur_m1 = in_word[2*LEN_W-1:LEN_W];
  assign f_src    = in_word[3*LEN_W-1:2*LEN_W];
  assign f_dst    = in_word[USED_W-1:3*LEN_W];

endmodule

// File: rtl/vl_csr_unit.sv
module vl_csr_unit
  import vlcsr_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int LEN_W  = 6,
  parameter int IMM_W  = 5,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] ADDR_CUR  = 12'hC20,
  parameter logic [ADDR_W-1:0] ADDR_MAX  = 12'hC21,
  parameter logic [ADDR_W-1:0] ADDR_PACK = 12'hC22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic              acc_imm,
  input  logic              acc_rd_zero,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [XLEN-1:0]   acc_wdata,
  output logic [XLEN-1:0]   rsp_rdata,
  output logic              rsp_exc
);

  localparam int LW = LEN_W + 1;
  localparam logic [LW-1:0] MAX_LEN = LW'(2 ** LEN_W);
  localparam logic [LW-1:0] ONE_LEN = LW'(1);

  // stored state
  logic [LW-1:0]    max_q, cur_q;
  logic [LEN_W-1:0] src_q, dst_q;

  csr_sel_e sel;

  vl_csr_decode #(
    .ADDR_W(ADDR_W), .ADDR_CUR(ADDR_CUR), .ADDR_MAX(ADDR_MAX), .ADDR_PACK(ADDR_PACK)
  ) u_dec (
    .addr(acc_addr),
    .sel (sel)
  );

  // write value: immediate forms of the length registers add one
  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] len_value;
  logic [XLEN-1:0] pack_value;
  logic            value_zero;

  assign imm_ext    = XLEN'(acc_wdata[IMM_W-1:0]);
  assign len_value  = acc_imm ? (imm_ext + XLEN'(1)) : acc_wdata;
  assign pack_value = acc_imm ? imm_ext : acc_wdata;
  assign value_zero = !acc_imm && (acc_wdata == '0);

  logic wr_any, wr_max, wr_cur, wr_pack, len_sel;

  assign wr_any  = acc_en && acc_wr;
  assign len_sel = (sel == SEL_MAX) || (sel == SEL_CUR);
  assign rsp_exc = wr_any && len_sel && value_zero;
  assign wr_max  = wr_any && (sel == SEL_MAX) && !value_zero;
  assign wr_cur  = wr_any && (sel == SEL_CUR) && !value_zero;
  assign wr_pack = wr_any && (sel == SEL_PACK);

  // maximum-length write path
  logic [LW-1:0] max_new, cur_after_max;

  vl_len_limit #(.VW(XLEN), .LW(LW)) u_lim_max (
    .value(len_value), .limit(MAX_LEN), .result(max_new)
  );

  vl_len_limit #(.VW(LW), .LW(LW)) u_lim_cur_shrink (
    .value(cur_q), .limit(max_new), .result(cur_after_max)
  );

  // current-length write path
  logic [LW-1:0] cur_new;

  vl_len_limit #(.VW(XLEN), .LW(LW)) u_lim_cur (
    .value(len_value), .limit(max_q), .result(cur_new)
  );

  // packed word path
  logic [XLEN-1:0]  pack_word;
  logic [LEN_W-1:0] f_max_m1, f_cur_m1, f_src, f_dst;

  vl_state_codec #(.XLEN(XLEN), .LEN_W(LEN_W)) u_codec (
    .max_len    (max_q),
    .cur_len    (cur_q),
    .src_off    (src_q),
    .dst_off    (dst_q),
    .packed_word(pack_word),
    .in_word    (pack_value),
    .f_max_m1   (f_max_m1),
    .f_cur_m1   (f_cur_m1),
    .f_src      (f_src),
    .f_dst      (f_dst)
  );

  logic [LW-1:0]    pk_max, pk_cur_req, pk_cur;
  logic [LEN_W-1:0] pk_cur_m1, pk_src, pk_dst;

  assign pk_max     = LW'(f_max_m1) + ONE_LEN;
  assign pk_cur_req = LW'(f_cur_m1) + ONE_LEN;

  vl_len_limit #(.VW(LW), .LW(LW)) u_lim_pk_cur (
    .value(pk_cur_req), .limit(pk_max), .result(pk_cur)
  );

  logic [LW-1:0] pk_cur_dec;
  assign pk_cur_dec = pk_cur - ONE_LEN;
  assign pk_cur_m1  = pk_cur_dec[LEN_W-1:0];

  vl_len_limit #(.VW(LEN_W), .LW(LEN_W)) u_lim_src (
    .value(f_src), .limit(pk_cur_m1), .result(pk_src)
  );

  vl_len_limit #(.VW(LEN_W), .LW(LEN_W)) u_lim_dst (
    .value(f_dst), .limit(pk_cur_m1), .result(pk_dst)
  );

  // response
  always_comb begin
    rsp_rdata = '0;
    if (acc_en && !rsp_exc && !acc_rd_zero) begin
      unique case (sel)
        SEL_MAX:  rsp_rdata = XLEN'(max_q);
        SEL_CUR:  rsp_rdata = wr_cur ? XLEN'(cur_new) : XLEN'(cur_q);
        SEL_PACK: rsp_rdata = pack_word;
        default:  rsp_rdata = '0;
      endcase
    end
  end

  // state update
  always_ff @(posedge clk) begin
    if (rst) begin
      max_q <= ONE_LEN;
      cur_q <= ONE_LEN;
      src_q <= '0;
      dst_q <= '0;
    end else if (wr_max) begin
      max_q <= max_new;
      cur_q <= cur_after_max;
    end else if (wr_cur) begin
      cur_q <= cur_new;
    end else if (wr_pack) begin
      max_q <= pk_max;
      cur_q <= pk_cur;
      src_q <= pk_src;
      dst_q <= pk_dst;
    end
  end

endmodule

// File: rtl/vl_csr_checker.sv
module vl_csr_checker #(
  parameter int XLEN  = 32,
  parameter int LEN_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             acc_en,
  input logic             acc_wr,
  input logic             acc_imm,
  input logic             acc_rd_zero,
  input logic             wr_cur,
  input logic             wr_pack,
  input logic             rsp_exc,
  input logic [XLEN-1:0]  rsp_rdata,
  input logic [LEN_W:0]   max_q,
  input logic [LEN_W:0]   cur_q,
  input logic [LEN_W-1:0] src_q,
  input logic [LEN_W-1:0] dst_q
);

  localparam logic [LEN_W:0] MAX_LEN = (LEN_W+1)'(2 ** LEN_W);

  AST_MAX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (max_q != '0) && (max_q <= MAX_LEN)); // R2

  AST_CUR_NOT_ABOVE_MAX: assert property (@(posedge clk) disable iff (rst)
    (cur_q != '0) && (cur_q <= max_q)); // R3

  AST_CUR_WRITE_RETURNS_NEW: assert property (@(posedge clk) disable iff (rst)
    (wr_cur && !acc_rd_zero) |=> (XLEN'(cur_q) == $past(rsp_rdata))); // R4

  AST_EXC_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
    rsp_exc |=> ($stable(max_q) && $stable(cur_q) && $stable(src_q) && $stable(dst_q))); // R6

  AST_EXC_REGISTER_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
    rsp_exc |-> (acc_en && acc_wr && !acc_imm && rsp_rdata == '0)); // R6

  AST_PACK_OFFSETS_BELOW_CUR: assert property (@(posedge clk) disable iff (rst)
    wr_pack |=> ((LEN_W+1)'(src_q) < cur_q && (LEN_W+1)'(dst_q) < cur_q)); // R10

  AST_READ_ONLY_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !acc_wr) |=> ($stable(max_q) && $stable(cur_q))); // R12

endmodule

bind vl_csr_unit vl_csr_checker #(.XLEN(XLEN), .LEN_W(LEN_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .acc_en     (acc_en),
  .acc_wr     (acc_wr),
  .acc_imm    (acc_imm),
  .acc_rd_zero(acc_rd_zero),
  .wr_cur     (wr_cur),
  .wr_pack    (wr_pack),
  .rsp_exc    (rsp_exc),
  .rsp_rdata  (rsp_rdata),
  .max_q      (max_q),
  .cur_q      (cur_q),
  .src_q      (src_q),
  .dst_q      (dst_q)
);

// File: tb/tb_vl_csr_unit.sv
module tb_vl_csr_unit;

  localparam logic [11:0] A_CUR  = 12'hC20;
  localparam logic [11:0] A_MAX  = 12'hC21;
  localparam logic [11:0] A_PACK = 12'hC22;
  localparam logic [11:0] A_NONE = 12'h7A0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_en = 1'b0, acc_wr = 1'b0, acc_imm = 1'b0, acc_rd_zero = 1'b0;
  logic [11:0] acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] rsp_rdata;
  logic        rsp_exc;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  vl_csr_unit dut (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr), .acc_imm(acc_imm),
    .acc_rd_zero(acc_rd_zero), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rsp_rdata(rsp_rdata), .rsp_exc(rsp_exc)
  );

  function automatic logic [31:0] pk(int m, int v, int s, int d);
    return 32'((m - 1) | ((v - 1) << 6) | (s << 12) | (d << 18));
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // one access: drive at falling edge, sample same-cycle response, commit at rising edge
  task automatic access(input logic [11:0] a, input logic wr, input logic imm,
                        input logic rdz, input logic [31:0] wd,
                        output logic [31:0] rd, output logic ex);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = wr; acc_imm = imm; acc_rd_zero = rdz;
    acc_addr = a; acc_wdata = wd;
    #1;
    rd = rsp_rdata; ex = rsp_exc;
    @(posedge clk);
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0; acc_imm = 1'b0; acc_rd_zero = 1'b0; acc_wdata = '0;
  endtask

  task automatic rd_reg(input logic [11:0] a, output logic [31:0] rd);
    logic ex;
    access(a, 1'b0, 1'b0, 1'b0, 32'd0, rd, ex);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd_reg(A_MAX, d);  check("R1 max after reset", d, 32'd1);
    rd_reg(A_CUR, d);  check("R1 cur after reset", d, 32'd1);
    rd_reg(A_PACK, d); check("R1 packed after reset", d, 32'd0);
  endtask

  task automatic t_max_write();
    logic [31:0] d; logic e;
    access(A_MAX, 1, 0, 0, 32'd20, d, e); check("R2 max write returns old", d, 32'd1);
    rd_reg(A_MAX, d); check("R2 max set to 20", d, 32'd20);
    access(A_MAX, 1, 1, 0, 32'd9, d, e); check("R2 imm max returns old", d, 32'd20);
    rd_reg(A_MAX, d); check("R2 imm max is imm+1", d, 32'd10);
    access(A_MAX, 1, 0, 0, 32'd100, d, e);
    rd_reg(A_MAX, d); check("R2 max limited to 64", d, 32'd64);
  endtask

  task automatic t_cur_write();
    logic [31:0] d; logic e;
    access(A_CUR, 1, 0, 0, 32'd10, d, e); check("R4 cur write returns new", d, 32'd10);
    access(A_CUR, 1, 0, 0, 32'd200, d, e); check("R3 cur limited to max 64", d, 32'd64);
    access(A_MAX, 1, 0, 0, 32'd20, d, e);
    rd_reg(A_CUR, d); check("R7 cur drops to new max", d, 32'd20);
    access(A_CUR, 1, 0, 0, 32'd50, d, e); check("R3 cur limited to max 20", d, 32'd20);
    access(A_CUR, 1, 1, 0, 32'd4, d, e); check("R5 imm cur is imm+1", d, 32'd5);
    rd_reg(A_CUR, d); check("R5 cur holds 5", d, 32'd5);
  endtask

  task automatic t_exception();
    logic [31:0] d; logic e;
    access(A_CUR, 1, 0, 0, 32'd0, d, e);
    check("R6 zero cur raises exc", 32'(e), 32'd1);
    check("R6 exc read data zero", d, 32'd0);
    access(A_CUR, 1'b0, 1'b0, 1'b0, 32'd0, d, e);
    check("R6 exc gone next access", 32'(e), 32'd0);
    check("R6 cur unchanged after exc", d, 32'd5);
    access(A_MAX, 1, 0, 0, 32'd0, d, e); check("R6 zero max raises exc", 32'(e), 32'd1);
    rd_reg(A_MAX, d); check("R6 max unchanged after exc", d, 32'd20);
    access(A_MAX, 1, 1, 0, 32'd0, d, e); check("R5 imm zero no exc", 32'(e), 32'd0);
    rd_reg(A_MAX, d); check("R2 imm zero gives max 1", d, 32'd1);
    rd_reg(A_CUR, d); check("R7 cur follows max to 1", d, 32'd1);
  endtask

  task automatic t_packed();
    logic [31:0] d; logic e; logic [31:0] w;
    w = 32'd39 | (32'd9 << 6) | (32'd7 << 12) | (32'd50 << 18) | (32'h1F << 24);
    access(A_PACK, 1, 0, 0, w, d, e);
    check("R9 packed write returns old", d, pk(1, 1, 0, 0));
    check("R9 packed write no exc", 32'(e), 32'd0);
    rd_reg(A_PACK, d); check("R10 dst offset limited, R8 reserved zero", d, pk(40, 10, 7, 9));
    rd_reg(A_MAX, d);  check("R9 max from low field", d, 32'd40);
    rd_reg(A_CUR, d);  check("R9 cur from second field", d, 32'd10);
    w = 32'd3 | (32'd20 << 6) | (32'd30 << 12) | (32'd2 << 18);
    access(A_PACK, 1, 0, 0, w, d, e);
    check("R9 second write returns old", d, pk(40, 10, 7, 9));
    rd_reg(A_PACK, d); check("R10 src limited and R9 cur limited to new max", d, pk(4, 4, 3, 2));
  endtask

  task automatic t_rd_zero();
    logic [31:0] d; logic e;
    access(A_CUR, 1, 0, 1, 32'd3, d, e); check("R11 rd zero gives no data", d, 32'd0);
    rd_reg(A_CUR, d); check("R11 write still applied", d, 32'd3);
    access(A_PACK, 1'b0, 1'b0, 1'b1, 32'd0, d, e); check("R11 rd zero read gives 0", d, 32'd0);
  endtask

  task automatic t_idle();
    logic [31:0] d; logic e;
    access(A_MAX, 1'b0, 1'b0, 1'b0, 32'd0, d, e);
    check("R12 read of zero data no exc", 32'(e), 32'd0);
    check("R12 max read", d, 32'd4);
    access(A_NONE, 1, 0, 0, 32'd0, d, e);
    check("R12 unmapped no exc", 32'(e), 32'd0);
    check("R12 unmapped reads 0", d, 32'd0);
    access(A_NONE, 1, 0, 0, 32'd17, d, e);
    rd_reg(A_PACK, d); check("R12 state untouched", d, pk(4, 3, 3, 2));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_max_write();
    t_cur_write();
    t_exception();
    t_packed();
    t_rd_zero();
    t_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule